// File: doc/BRIEF.md
# Infrared Carrier Burst Generator

This block produces the modulated carrier that drives an infrared transmitter LED. A counter, advanced by a selectable power-of-two division of the system clock, runs through a high phase and a low phase. Each phase has its own modulo register, so software sets both the carrier frequency and its duty. The carrier appears on the output only while an internal active-level bit is 1.

Software never writes the active level directly. It writes a pending level, and that value moves into the active level on the next pulse of an external period tick. That tick comes from the timer that measures the lengths of the marks and spaces. This keeps every mark and space aligned to that timer, whatever the write latency. A disable bit turns the modulation off, and the output then carries the plain active level. Every burst starts with a complete high phase. Modulo values written during a burst take effect at the next phase boundary.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset the output is low and all registers are 0. A period tick with no prior level write leaves the output low.
- R2: A high-modulo value h, written at address 0, gives a high phase of exactly h+1 counter clocks.
- R3: A low-modulo value l, written at address 1, gives a low phase of exactly l+1 counter clocks. High and low phases then alternate for as long as the active level is 1.
- R4: While the active level is 0 the output is low. Writing the pending level without a period tick does not change the output.
- R5: The pending level is bit 0 at address 3. It is copied into the active level only on a cycle where the period tick is 1, and the output reflects the new level from the clock edge that samples the tick.
- R6: When the disable bit (bit 0 at address 2) is 1, the output equals the active level with no modulation.
- R7: Bits 2:1 at address 2 select the counter clock, which is the system clock divided by 2 to the power of the field value (1, 2, 4 or 8).
- R8: When the active level goes from 0 to 1, the counter and the divider restart and the output begins a full high phase.
- R9: When the active level goes from 1 to 0, the output is low from that same edge onward, even in the middle of a high phase.
- R10: A modulo write during a burst does not shorten or lengthen the current phase. The new value governs the next phase of that kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 high modulo, 1 low modulo, 2 control, 3 pending level) |
| wr_data | input | 8 | Register write data |
| tmr_tick | input | 1 | Period tick from the mark/space timer |
| carrier_out | output | 1 | Modulated carrier output |

## Verification
The assertions check several rules on every cycle. The phase counter must never pass the limit of its current phase. The limit may change only when the counter is at zero, so a mid-phase write cannot reach it. The active level must hold between ticks, and every rising edge of that level must land on a cleared counter in the high phase. The divider must restart cleanly. Exact waveforms can only be shown by the bench scenarios: the phase lengths for given modulo values and divide settings, the boundary at which a mid-burst modulo write takes hold, the abrupt cut on a falling level, and the unmodulated output when the disable bit is set.

// File: rtl/ir_carrier_pkg.sv
`timescale 1ns/1ps
package ir_carrier_pkg;
   localparam int unsigned REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      RA_HI_MOD = 2'd0,
      RA_LO_MOD = 2'd1,
      RA_CTRL   = 2'd2,
      RA_LEVEL  = 2'd3
   } reg_addr_e;

   // control register field positions
   localparam int unsigned CTRL_OFF_BIT = 0;
   localparam int unsigned CTRL_SEL_LSB = 1;
endpackage

// File: rtl/ir_reg_bank.sv
`timescale 1ns/1ps
module ir_reg_bank
   import ir_carrier_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] hi_mod,
   output logic [DATA_W-1:0] lo_mod,
   output logic              carrier_off,
   output logic [SEL_W-1:0]  div_sel,
   output logic              lvl_pend
);
   localparam int unsigned SEL_MSB = CTRL_SEL_LSB + SEL_W - 1;

   if (SEL_MSB >= DATA_W) begin : g_bad_ctrl
      $error("control fields do not fit in the data width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_mod      <= '0;
         lo_mod      <= '0;
         carrier_off <= 1'b0;
         div_sel     <= '0;
         lvl_pend    <= 1'b0;
      end else if (wr_en) begin
         unique case (reg_addr_e'(wr_addr))
            RA_HI_MOD: hi_mod <= wr_data;
            RA_LO_MOD: lo_mod <= wr_data;
            RA_CTRL: begin
               carrier_off <= wr_data[CTRL_OFF_BIT];
               div_sel     <= wr_data[SEL_MSB:CTRL_SEL_LSB];
            end
            RA_LEVEL:  lvl_pend <= wr_data[0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ir_clk_div.sv
`timescale 1ns/1ps
module ir_clk_div #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned NSEL  = 1 << SEL_W;
   localparam int unsigned PRE_W = (NSEL > 1) ? NSEL - 1 : 1;

   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("SEL_W must be 1 to 3");
   end

   logic [PRE_W-1:0] pre;
   logic [NSEL-1:0]  taps;

   // one tap per divide option: ratio 2**s fires when low s bits are all one
   for (genvar s = 0; s < NSEL; s++) begin : g_tap
      if (s == 0) begin : g_direct
         assign taps[s] = 1'b1;
      end else begin : g_div
         assign taps[s] = &pre[s-1:0];
      end
   end

   assign tick = taps[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre <= '0;
      else if (clr) pre <= '0;
      else          pre <= pre + 1'b1;
   end

   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (tick == (sel == '0)));
endmodule

// File: rtl/ir_phase_ctr.sv
`timescale 1ns/1ps
module ir_phase_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             adv,
   input  logic [CNT_W-1:0] hi_lim,
   input  logic [CNT_W-1:0] lo_lim,
   output logic             phase_hi
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;   // limit of the phase in progress, latched at boundaries
   logic             at_end;

   assign at_end = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         phase_hi <= 1'b1;
         lim      <= '0;
      end else if (!run) begin
         cnt      <= '0;
         phase_hi <= 1'b1;
         lim      <= hi_lim;
      end else if (adv) begin
         if (at_end) begin
            cnt      <= '0;
            phase_hi <= !phase_hi;
            lim      <= phase_hi ? lo_lim : hi_lim;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);
   p_burst_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt == '0 && phase_hi));
   p_lim_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> $stable(lim));
endmodule

// File: rtl/ir_carrier_gen.sv
`timescale 1ns/1ps
module ir_carrier_gen
   import ir_carrier_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              tmr_tick,
   output logic              carrier_out
);
   logic [CNT_W-1:0] hi_mod, lo_mod;
   logic             carrier_off;
   logic [SEL_W-1:0] div_sel;
   logic             lvl_pend;
   logic             lvl_act;
   logic             cnt_tick;
   logic             phase_hi;

   ir_reg_bank #(.DATA_W(CNT_W), .SEL_W(SEL_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .hi_mod      (hi_mod),
      .lo_mod      (lo_mod),
      .carrier_off (carrier_off),
      .div_sel     (div_sel),
      .lvl_pend    (lvl_pend)
   );

   // active level moves only on the period tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lvl_act <= 1'b0;
      else if (tmr_tick) lvl_act <= lvl_pend;
   end

   ir_clk_div #(.SEL_W(SEL_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!lvl_act),
      .sel   (div_sel),
      .tick  (cnt_tick)
   );

   ir_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (lvl_act),
      .adv      (cnt_tick),
      .hi_lim   (hi_mod),
      .lo_lim   (lo_mod),
      .phase_hi (phase_hi)
   );

   assign carrier_out = lvl_act & (carrier_off | phase_hi);

   p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_tick |=> $stable(lvl_act));
   p_burst_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_act) |-> carrier_out);
endmodule

// File: tb/ir_carrier_gen_bench.sv
`timescale 1ns/1ps
module ir_carrier_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tmr_tick = 1'b0;
   logic       carrier_out;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   ir_carrier_gen u_ir_carrier_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tmr_tick(tmr_tick), .carrier_out(carrier_out)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: out=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_tick();
      tmr_tick = 1'b1;
      @(negedge clk);
      tmr_tick = 1'b0;
   endtask

   task automatic set_level(input logic v);
      wr(2'd3, {7'd0, v});
      pulse_tick();
   endtask

   task automatic check_pattern(input int h, input int l, input int d, input int n, input string tag);
      int p;
      p = (h + 1 + l + 1) * d;
      for (int i = 0; i < n; i++) begin
         chk(carrier_out, ((i % p) < (h + 1) * d), tag);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(carrier_out, 1'b0, "R1 reset out");
      pulse_tick();
      for (int i = 0; i < 4; i++) begin
         chk(carrier_out, 1'b0, "R1 tick with cleared buffer");
         @(negedge clk);
      end
   endtask

   task automatic t_buffer_only();
      wr(2'd3, 8'd1);
      for (int i = 0; i < 5; i++) begin
         chk(carrier_out, 1'b0, "R4 pending write without tick");
         @(negedge clk);
      end
      pulse_tick();
      chk(carrier_out, 1'b1, "R5 level taken on tick");
      set_level(1'b0);
   endtask

   task automatic t_basic();
      wr(2'd0, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'd0);
      set_level(1'b1);
      check_pattern(0, 0, 1, 10, "R2 R3 R8 h0 l0");
      set_level(1'b0);
      wr(2'd0, 8'd1); wr(2'd1, 8'd2);
      set_level(1'b1);
      check_pattern(1, 2, 1, 15, "R2 R3 R8 h1 l2");
      set_level(1'b0);
   endtask

   task automatic t_divide();
      wr(2'd0, 8'd0); wr(2'd1, 8'd1); wr(2'd2, 8'b0000_0100);
      set_level(1'b1);
      check_pattern(0, 1, 4, 24, "R7 divide by 4");
      set_level(1'b0);
      wr(2'd2, 8'b0000_0110);
      set_level(1'b1);
      check_pattern(0, 1, 8, 24, "R7 divide by 8");
      set_level(1'b0);
      wr(2'd2, 8'd0);
   endtask

   task automatic t_midwrite();
      wr(2'd0, 8'd3); wr(2'd1, 8'd3);
      set_level(1'b1);
      chk(carrier_out, 1'b1, "R10 first high");
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd0;
      @(negedge clk);
      wr_addr = 2'd1;
      chk(carrier_out, 1'b1, "R10 high 1");
      @(negedge clk);
      wr_en = 1'b0;
      chk(carrier_out, 1'b1, "R10 high 2");
      @(negedge clk);
      chk(carrier_out, 1'b1, "R10 high 3 kept");
      @(negedge clk);
      chk(carrier_out, 1'b0, "R10 new low length");
      @(negedge clk);
      chk(carrier_out, 1'b1, "R10 new high length");
      @(negedge clk);
      chk(carrier_out, 1'b0, "R10 next low");
      @(negedge clk);
      set_level(1'b0);
   endtask

   task automatic t_fall();
      wr(2'd0, 8'd9); wr(2'd1, 8'd0);
      set_level(1'b1);
      @(negedge clk);
      chk(carrier_out, 1'b1, "R9 inside high phase");
      set_level(1'b0);
      for (int i = 0; i < 12; i++) begin
         chk(carrier_out, 1'b0, "R9 cut at level drop");
         @(negedge clk);
      end
   endtask

   task automatic t_disable();
      wr(2'd0, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'd1);
      set_level(1'b1);
      for (int i = 0; i < 6; i++) begin
         chk(carrier_out, 1'b1, "R6 unmodulated high");
         @(negedge clk);
      end
      set_level(1'b0);
      chk(carrier_out, 1'b0, "R6 unmodulated low");
      wr(2'd2, 8'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_buffer_only();
      t_basic();
      t_divide();
      t_midwrite();
      t_fall();
      t_disable();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #800000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: out=%0b expected finish", carrier_out);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule